// File: doc/BRIEF.md
# Strap-addressed I2C register target

This block sits on a two-wire serial bus as a target and turns bus transactions into accesses on a simple internal register bus. It never drives the clock line; it only pulls the data line low through an open-drain enable. Both bus lines are brought into the system clock domain through synchronizers. Start, stop and clock edges are then detected from the synchronized samples. The system clock must run at least eight times the bus clock rate.

Two strap inputs are captured while reset is held. The value 00 disables the bus function entirely: the block then stays silent, because the pins are serving another serial mode. Any other value selects a 7-bit target address. The address has the fixed upper bits 11000, and its two low bits equal the strap value minus one.

A write transaction carries the target address, then a 16-bit register address as two bytes, then any number of data bytes. Each data byte lands in successive registers. A read starts with a write transaction that sets the register address. It is followed by a repeated start and the target address with the read direction, and the block then streams bytes from successive registers until the controller declines one.

Top module: `strap_i2c_target`

## Requirements
- R1: `strap` is captured only while `rstN` is low; a change of `strap` after reset is released has no effect on which address is answered.
- R2: With a captured strap of 00 the block never pulls SDA low and never raises `regWe` or `regRe`, whatever traffic appears on the bus.
- R3: With a captured strap s of 01, 10 or 11 the block answers only the 7-bit address {11000, s-1}, i.e. 0x60, 0x61 and 0x62 respectively. A byte carrying any other address is not acknowledged, and the rest of that transaction is ignored.
- R4: For every byte it receives in an addressed transaction, the block holds SDA low (`sdaOe`=1) during the ninth clock pulse. `sdaOe` changes only while SCL is low, and it is 0 after reset.
- R5: After the address byte with the write bit (bit 0 = 0), the next two bytes set the register address, high byte first. Each later byte produces a one-cycle `regWe` with `regAddr` and `regWdata` valid. The address then advances by one, wrapping from 0xFFFF to 0x0000.
- R6: After a repeated start and the address byte with the read bit (bit 0 = 1), the block sends bytes MSB first, starting at the current register address. Each byte is fetched by a one-cycle `regRe`, with `regRdata` taken in that same cycle. The address advances by one after every byte sent.
- R7: When the controller does not acknowledge a sent byte, the block fetches no further byte and releases SDA. It leaves SDA released until the next start or stop.
- R8: A start or stop arriving before the eighth bit of a byte aborts the transaction with no register write. A start restarts address reception at once.
- R9: `regWe` and `regRe` are never high in the same cycle, and each is high for one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; straps are captured while low |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap | input | 2 | Strap pins selecting disable or the address low bits |
| regAddr | output | 16 | Register bus address |
| regWdata | output | 8 | Register bus write data |
| regRdata | input | 8 | Register bus read data, taken in the `regRe` cycle |
| regWe | output | 1 | Register write strobe, one cycle |
| regRe | output | 1 | Register read strobe, one cycle |

## Verification
A wrong byte phase or bit count shows at the ports within one byte time. The ninth-clock acknowledge goes missing or moves, a register write appears with the wrong address or data, or read data comes back shifted. An address pointer that fails to advance or wrap shows up in the next `regWe` or `regRe` of the same burst. A state that keeps driving after a declined byte corrupts the very next bus bit. A capture of the straps outside reset changes which address is acknowledged on the first transaction after the pins move.

// File: rtl/strap_i2c_pkg.sv
`timescale 1ns/1ps
package strap_i2c_pkg;
  localparam int BYTE_W     = 8;
  localparam int REG_ADDR_W = 16;
  localparam int STRAP_W    = 2;
  localparam int DEV_W      = 7;
  localparam logic [DEV_W-STRAP_W-1:0] DEV_FIXED = 5'b11000;
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX, ST_RXDONE, ST_LOADFIRST, ST_ACKSET, ST_ACKHOLD,
    ST_ACKEND, ST_TX, ST_TXACK, ST_LOADNEXT, ST_TXWAIT
  } ctrlState_t;

  typedef enum logic [1:0] { PH_DEV, PH_AHI, PH_ALO, PH_DATA } bytePhase_t;

  typedef struct packed {
    logic shiftIn;
    logic ldAddrHi;
    logic ldAddrLo;
    logic incAddr;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic txOn;
    logic regWe;
    logic regRe;
  } ctrlStrb_t;
endpackage

// File: rtl/strap_i2c_dp.sv
`timescale 1ns/1ps
module strap_i2c_dp
  import strap_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [STRAP_W-1:0]    strap,
  input  ctrlStrb_t             strb,
  input  logic [BYTE_W-1:0]     regRdata,
  output logic                  sclRise,
  output logic                  sclFall,
  output logic                  startDet,
  output logic                  stopDet,
  output logic                  sdaBit,
  output logic                  enabled,
  output logic                  devMatch,
  output logic                  rwBit,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0]     regWdata,
  output logic                  sdaOe
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic [STRAP_W-1:0] strapReg;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [DEV_W-1:0] devAddr;

  // strap capture happens only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) strapReg <= strap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit   = sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      regAddr <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (strb.loadTx) txShift <= regRdata;
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strb.ldAddrHi) regAddr[REG_ADDR_W-1:BYTE_W] <= rxShift;
      else if (strb.ldAddrLo) regAddr[BYTE_W-1:0] <= rxShift;
      else if (strb.incAddr) regAddr <= regAddr + 1'b1;
    end
  end

  assign devAddr  = {DEV_FIXED, strapReg - 2'd1};
  assign enabled  = |strapReg;
  assign devMatch = (rxShift[BYTE_W-1:1] == devAddr);
  assign rwBit    = rxShift[0];
  assign regWdata = rxShift;
  assign sdaOe    = strb.ackOn | (strb.txOn & ~txShift[BYTE_W-1]);
endmodule

// File: rtl/strap_i2c_ctrl.sv
`timescale 1ns/1ps
module strap_i2c_ctrl
  import strap_i2c_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaBit,
  input  logic      enabled,
  input  logic      devMatch,
  input  logic      rwBit,
  output ctrlStrb_t strb
);
  ctrlState_t state, stNext;
  bytePhase_t phase, phNext;
  logic readMode, rdNext;
  logic [2:0] bitCnt, cntNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_DEV;
      readMode <= 1'b0;
      bitCnt   <= '0;
    end else begin
      state    <= stNext;
      phase    <= phNext;
      readMode <= rdNext;
      bitCnt   <= cntNext;
    end
  end

  always_comb begin
    stNext  = state;
    phNext  = phase;
    rdNext  = readMode;
    cntNext = bitCnt;
    strb    = '0;
    case (state)
      ST_RX: if (sclRise) begin
        strb.shiftIn = 1'b1;
        if (bitCnt == LAST_BIT) stNext = ST_RXDONE;
        else cntNext = bitCnt + 1'b1;
      end
      ST_RXDONE: begin
        stNext = ST_ACKSET;
        case (phase)
          PH_DEV: begin
            if (!devMatch) stNext = ST_IDLE;
            else if (rwBit) begin
              rdNext = 1'b1;
              stNext = ST_LOADFIRST;
            end else phNext = PH_AHI;
          end
          PH_AHI: begin
            strb.ldAddrHi = 1'b1;
            phNext = PH_ALO;
          end
          PH_ALO: begin
            strb.ldAddrLo = 1'b1;
            phNext = PH_DATA;
          end
          default: begin
            strb.regWe   = 1'b1;
            strb.incAddr = 1'b1;
          end
        endcase
      end
      ST_LOADFIRST: begin
        strb.regRe  = 1'b1;
        strb.loadTx = 1'b1;
        stNext = ST_ACKSET;
      end
      ST_ACKSET: if (sclFall) stNext = ST_ACKHOLD;
      ST_ACKHOLD: if (sclRise) stNext = ST_ACKEND;
      ST_ACKEND: if (sclFall) begin
        cntNext = '0;
        stNext  = readMode ? ST_TX : ST_RX;
      end
      ST_TX: if (sclFall) begin
        if (bitCnt == LAST_BIT) stNext = ST_TXACK;
        else begin
          strb.shiftTx = 1'b1;
          cntNext = bitCnt + 1'b1;
        end
      end
      ST_TXACK: if (sclRise) begin
        strb.incAddr = 1'b1;
        stNext = sdaBit ? ST_IDLE : ST_LOADNEXT;
      end
      ST_LOADNEXT: begin
        strb.regRe  = 1'b1;
        strb.loadTx = 1'b1;
        stNext = ST_TXWAIT;
      end
      ST_TXWAIT: if (sclFall) begin
        cntNext = '0;
        stNext  = ST_TX;
      end
      default: ;
    endcase
    strb.ackOn = (state == ST_ACKHOLD) || (state == ST_ACKEND);
    strb.txOn  = (state == ST_TX);
    if (stopDet) stNext = ST_IDLE;
    else if (startDet && enabled) begin
      stNext  = ST_RX;
      phNext  = PH_DEV;
      rdNext  = 1'b0;
      cntNext = '0;
    end
  end
endmodule

// File: rtl/strap_i2c_target.sv
`timescale 1ns/1ps
module strap_i2c_target
  import strap_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [STRAP_W-1:0]    strap,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0]     regWdata,
  input  logic [BYTE_W-1:0]     regRdata,
  output logic                  regWe,
  output logic                  regRe
);
  ctrlStrb_t strb;
  logic sclRise, sclFall, startDet, stopDet, sdaBit, enabled, devMatch, rwBit;

  strap_i2c_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .strb(strb), .regRdata(regRdata), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .enabled(enabled),
    .devMatch(devMatch), .rwBit(rwBit), .regAddr(regAddr), .regWdata(regWdata),
    .sdaOe(sdaOe)
  );

  strap_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .enabled(enabled),
    .devMatch(devMatch), .rwBit(rwBit), .strb(strb)
  );

  assign regWe = strb.regWe;
  assign regRe = strb.regRe;
endmodule

// File: rtl/strap_i2c_chk.sv
`timescale 1ns/1ps
module strap_i2c_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  strap,
  input logic        sclIn,
  input logic        sdaOe,
  input logic        regWe,
  input logic        regRe,
  input logic [15:0] regAddr
);
  logic [1:0] strapSeen;
  always_ff @(posedge clk) begin
    if (!rstN) strapSeen <= strap;
  end

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (strapSeen == 2'b00) |-> (!sdaOe && !regWe && !regRe)); // R2
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R4
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> (regAddr == $past(regAddr) + 16'd1)); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> !regRe); // R6
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe)); // R9
endmodule

bind strap_i2c_target strap_i2c_chk u_chk (
  .clk(clk), .rstN(rstN), .strap(strap), .sclIn(sclIn), .sdaOe(sdaOe),
  .regWe(regWe), .regRe(regRe), .regAddr(regAddr)
);

// File: tb/strap_i2c_target_tb.sv
`timescale 1ns/1ps
module strap_i2c_target_tb;
  localparam int QTR = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sdaOe, regWe, regRe;
  logic [15:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic sdaLine;
  assign sdaLine = sdaM & ~sdaOe;

  strap_i2c_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strap(strap), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regWe(regWe), .regRe(regRe)
  );

  int checks = 0, errors = 0;
  int wCnt = 0, rCnt = 0, overlap = 0, longWe = 0;
  logic prevWe = 1'b0;
  logic [7:0] mem [0:255];
  bit memValid [0:255];
  logic [15:0] wAddr [0:255];
  logic [7:0] wData [0:255];

  function automatic logic [7:0] initVal(logic [7:0] a);
    return a ^ 8'h5A;
  endfunction
  function automatic logic [6:0] expDev(logic [1:0] s);
    return {5'b11000, s - 2'd1};
  endfunction

  assign regRdata = memValid[regAddr[7:0]] ? mem[regAddr[7:0]] : initVal(regAddr[7:0]);

  always @(posedge clk) begin
    if (regWe) begin
      mem[regAddr[7:0]] <= regWdata;
      memValid[regAddr[7:0]] <= 1'b1;
      wAddr[wCnt[7:0]] <= regAddr;
      wData[wCnt[7:0]] <= regWdata;
      wCnt <= wCnt + 1;
    end
    if (regRe) rCnt <= rCnt + 1;
    if (regWe && regRe) overlap <= overlap + 1;
    if (regWe && prevWe) longWe <= longWe + 1;
    prevWe <= regWe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ;
    repeat (QTR) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] s);
    rstN = 1'b0; strap = s; sclM = 1'b1; sdaM = 1'b1;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic startC;
    sdaM = 1'b1; waitQ; sclM = 1'b1; waitQ; sdaM = 1'b0; waitQ; sclM = 1'b0; waitQ;
  endtask
  task automatic stopC;
    sdaM = 1'b0; waitQ; sclM = 1'b1; waitQ; sdaM = 1'b1; waitQ;
  endtask
  task automatic sendBit(input logic b, output logic r);
    sdaM = b; waitQ; sclM = 1'b1; waitQ; r = sdaLine; waitQ; sclM = 1'b0; waitQ;
  endtask
  task automatic writeByte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) sendBit(d[i], r);
    sendBit(1'b1, r);
    acked = ~r;
  endtask
  task automatic readByte(input logic giveAck, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      sendBit(1'b1, r);
      d[i] = r;
    end
    sendBit(~giveAck, r);
  endtask

  task automatic setAddr(input logic [6:0] dev, input logic [15:0] a, output logic [2:0] m);
    startC;
    writeByte({dev, 1'b0}, m[0]);
    writeByte(a[15:8], m[1]);
    writeByte(a[7:0], m[2]);
  endtask

  task automatic regWrite(input logic [6:0] dev, input logic [15:0] a,
                          input logic [31:0] bytesIn, input int n, output logic [7:0] mask);
    logic [2:0] m;
    mask = '0;
    setAddr(dev, a, m);
    mask[2:0] = m;
    for (int i = 0; i < n; i++) writeByte(bytesIn[8*i +: 8], mask[3+i]);
    stopC;
  endtask

  task automatic regRead(input logic [6:0] dev, input logic [15:0] a, input int n,
                         output logic [31:0] got, output logic [3:0] mask);
    logic [2:0] m;
    logic [7:0] d;
    got = '0;
    setAddr(dev, a, m);
    mask[2:0] = m;
    startC;
    writeByte({dev, 1'b1}, mask[3]);
    for (int i = 0; i < n; i++) begin
      readByte(i != n - 1, d);
      got[8*i +: 8] = d;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] mask;
    logic [3:0] rmask;
    logic [31:0] got;
    logic [7:0] d;
    logic r, ak;
    int w0, r0;

    doReset(2'b01);
    chk("R4 sdaOe after reset", sdaOe, 0);
    chk("R9 strobes after reset", {regWe, regRe}, 0);

    // basic write burst at strap 01
    w0 = wCnt;
    regWrite(expDev(2'b01), 16'h1234, 32'h00003CA5, 2, mask);
    chk("R4 acks on write", mask, 8'h1F);
    chk("R5 write count", wCnt - w0, 2);
    chk("R5 first addr", wAddr[w0[7:0]], 16'h1234);
    chk("R5 first data", wData[w0[7:0]], 8'hA5);
    chk("R5 second addr", wAddr[w0[7:0]+1], 16'h1235);
    chk("R5 second data", wData[w0[7:0]+1], 8'h3C);

    // read back three bytes, the last declined, then clock one more byte
    r0 = rCnt;
    regRead(expDev(2'b01), 16'h1234, 3, got, rmask);
    chk("R4 acks on read setup", rmask, 4'hF);
    chk("R6 read bytes", got[23:0], {initVal(8'h36), 8'h3C, 8'hA5});
    readByte(1'b0, d);
    chk("R7 SDA released after decline", d, 8'hFF);
    chk("R7 fetch count", rCnt - r0, 3);
    stopC;

    // wrong address under strap 01
    w0 = wCnt;
    regWrite(7'h61, 16'h0010, 32'h77, 1, mask);
    chk("R3 other address ignored", mask, 0);
    chk("R3 no write for other address", wCnt - w0, 0);

    // address map for the other strap values
    doReset(2'b10);
    regWrite(7'h61, 16'h00FF, 32'h11, 1, mask);
    chk("R3 strap 10 answers 0x61", mask, 8'h0F);
    regWrite(7'h60, 16'h00FF, 32'h11, 1, mask);
    chk("R3 strap 10 ignores 0x60", mask, 0);
    doReset(2'b11);
    regWrite(expDev(2'b11), 16'h0020, 32'h22, 1, mask);
    chk("R3 strap 11 answers 0x62", mask, 8'h0F);

    // disabled mode
    doReset(2'b00);
    w0 = wCnt; r0 = rCnt;
    for (int k = 0; k < 3; k++) begin
      regWrite(7'h60 + 7'(k), 16'h0030, 32'h33, 1, mask);
      chk("R2 disabled never acks", mask, 0);
    end
    regRead(7'h60, 16'h0030, 1, got, rmask);
    stopC;
    chk("R2 disabled read acks", rmask, 0);
    chk("R2 disabled strobes", (wCnt - w0) + (rCnt - r0), 0);

    // straps moved after reset have no effect
    doReset(2'b01);
    strap = 2'b11;
    repeat (4) @(negedge clk);
    regWrite(7'h62, 16'h0040, 32'h44, 1, mask);
    chk("R1 late strap ignored", mask, 0);
    regWrite(7'h60, 16'h0040, 32'h44, 1, mask);
    chk("R1 captured strap kept", mask, 8'h0F);

    // abort by start in the middle of a data byte
    w0 = wCnt;
    setAddr(7'h60, 16'h0050, mask[2:0]);
    for (int i = 0; i < 4; i++) sendBit(1'b1, r);
    startC;
    writeByte({7'h60, 1'b0}, ak);
    chk("R8 restart accepted", ak, 1);
    stopC;
    chk("R8 no write after start abort", wCnt - w0, 0);
    // abort by stop in the middle of a data byte
    setAddr(7'h60, 16'h0050, mask[2:0]);
    for (int i = 0; i < 5; i++) sendBit(1'b0, r);
    stopC;
    chk("R8 no write after stop abort", wCnt - w0, 0);

    // address wrap at the top of the space
    w0 = wCnt;
    regWrite(7'h60, 16'hFFFF, 32'h00009988, 2, mask);
    chk("R5 wrap count", wCnt - w0, 2);
    chk("R5 wrap addr", wAddr[w0[7:0]+1], 16'h0000);

    // random bursts, written then read back
    void'($urandom(32'h00C0FFEE));
    for (int t = 0; t < 6; t++) begin
      logic [15:0] ra;
      logic [31:0] rd;
      int n;
      ra = 16'($urandom);
      rd = $urandom;
      n = 1 + int'($urandom % 3);
      w0 = wCnt;
      regWrite(7'h60, ra, rd, n, mask);
      chk("R5 random write count", wCnt - w0, n);
      for (int i = 0; i < n; i++) begin
        chk("R5 random write addr", wAddr[w0[7:0]+8'(i)], 32'(ra + 16'(i)));
        chk("R5 random write data", wData[w0[7:0]+8'(i)], rd[8*i +: 8]);
      end
      regRead(7'h60, ra, n, got, rmask);
      stopC;
      for (int i = 0; i < n; i++)
        chk("R6 random read data", got[8*i +: 8], rd[8*i +: 8]);
    end

    chk("R9 strobes overlap", overlap, 0);
    chk("R9 write strobe width", longWe, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule